// File: doc/BRIEF.md
# Way-Predicting Branch Target Buffer

This block is a set-associative branch target buffer that also predicts which way of a 4-way instruction cache holds the next fetch. One combinational lookup on the fetch address returns the branch target and a cache way index in the same cycle. The fetch unit uses the way index to enable a single cache way when a prediction exists, and all four ways when it does not.

Entries are created for non-branch fetches as well as branches, so that more fetches carry a way prediction. The buffer ways are split into two groups. The low ways hold only branch entries and the high ways hold only non-branch entries. A non-branch hit gives only a way prediction and reports a zero target.

When the resolution side reports a cache way that differs from the stored one, the entry is corrected and a one-cycle flag tells the fetch unit to replay the fetch with all ways enabled. Each group of ways keeps its own least-recently-used order in each set.

Top module: `wp_btb`

## Requirements
- R1: After the asynchronous reset `rst_ni` no entry is valid: no fetch hits, `way_en_o` is 4'b1111 and `mispred_o` is 0.
- R2: In the same cycle as a valid fetch, `hit_o` and `wp_valid_o` are 1 exactly when the indexed set holds a valid entry with a matching tag. `wp_way_o` then gives that entry's stored cache way, and `tgt_o` gives its target when the entry is a branch.
- R3: `way_en_o` is the one-hot decode of `wp_way_o` on a hit, with bit i enabling cache way i. Otherwise it is 4'b1111.
- R4: A hit on a non-branch entry drives `is_br_o` = 0 and `tgt_o` = 0. A hit on a branch entry drives `is_br_o` = 1.
- R5: A branch update (`upd_is_br_i` = 1) only ever occupies buffer ways below `BR_WAYS`, and a non-branch update only the ways at or above it. An update whose type differs from an existing entry for the same address invalidates that old entry.
- R6: An update whose address matches a valid entry of its own type rewrites that entry's target and cache way in place, with no new allocation.
- R7: `mispred_o` is 1 for exactly the one cycle after an update that matched a valid entry of its own type whose stored cache way differed from `upd_way_i`, and 0 otherwise.
- R8: An allocation picks the lowest-numbered invalid way of its group. If the group is full, it picks the group's least recently used way.
- R9: Every valid fetch hit and every update makes the touched way the most recent in its group. When a fetch hit and an update touch the same set and the same group in one cycle, only the update's touch is applied.
- R10: The set index is `pc[IDX_LSB +: log2(SETS)]` and the tag is all bits above it. A fetch with `fetch_valid_i` = 0 never hits, and addresses that differ only in the tag do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetch lookup request |
| fetch_pc_i | input | PC_W | Fetch address |
| hit_o | output | 1 | Lookup hit |
| is_br_o | output | 1 | Hit entry is a branch |
| tgt_o | output | PC_W | Predicted branch target |
| wp_valid_o | output | 1 | Way prediction available |
| wp_way_o | output | 2 | Predicted cache way |
| way_en_o | output | 4 | Cache way enables |
| upd_valid_i | input | 1 | Resolution update |
| upd_pc_i | input | PC_W | Resolved fetch address |
| upd_is_br_i | input | 1 | Resolved fetch was a branch |
| upd_tgt_i | input | PC_W | Resolved taken target |
| upd_way_i | input | 2 | Cache way that held the line |
| mispred_o | output | 1 | Way mispredicted, replay with all ways |

## Verification
The bench builds the block with `SETS` = 4, `BR_WAYS` = 1 and `PC_W` = 16, and draws tags from a small pool. Sets therefore overflow within a few updates, and groups of one way and of three ways both see eviction. The three-way group makes the least-recently-used order observable beyond a single bit. Type changes, in-place rewrites and fetch/update collisions on one set also occur often in random traffic, and a behavioural model predicts every output on every cycle.

// File: rtl/wp_btb_pkg.sv
package wp_btb_pkg;
  localparam int unsigned IC_WAYS  = 4;
  localparam int unsigned IC_WAY_W = 2;

  typedef logic [IC_WAY_W-1:0] icway_t;
  typedef logic [IC_WAYS-1:0]  icen_t;

  function automatic icen_t icway_dec(icway_t w);
    icen_t e;
    e    = '0;
    e[w] = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/wp_btb_match.sv
module wp_btb_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 24
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           q_i,
  output logic [WAYS-1:0]            hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_o[w] = vld_i[w] && (tag_i[w] == q_i);
  end
endmodule

// File: rtl/wp_btb_repl.sv
module wp_btb_repl #(
  parameter int unsigned SETS    = 64,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned BR_WAYS = 2,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             f_touch_i,
  input  logic [SET_W-1:0] f_set_i,
  input  logic [WAY_W-1:0] f_way_i,
  input  logic             u_touch_i,
  input  logic [SET_W-1:0] u_set_i,
  input  logic [WAY_W-1:0] u_way_i,
  input  logic             u_br_i,
  input  logic [WAYS-1:0]  u_vld_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam int unsigned AGE_W = (WAY_W > 0) ? WAY_W : 1;
  typedef logic [WAYS-1:0][AGE_W-1:0] row_t;

  row_t age_q [SETS];
  row_t row_f, row_u, row_ub;
  logic f_eff;

  function automatic logic in_br(int unsigned w);
    return w < BR_WAYS;
  endfunction

  function automatic row_t touch(row_t r, int unsigned w);
    row_t o;
    o = r;
    for (int unsigned x = 0; x < WAYS; x++)
      if (in_br(x) == in_br(w) && r[x] < r[w]) o[x] = r[x] + 1'b1;
    o[w] = '0;
    return o;
  endfunction

  // same set and same group: the update's touch wins
  always_comb begin
    f_eff  = f_touch_i && !(u_touch_i && f_set_i == u_set_i &&
                            in_br(32'(f_way_i)) == in_br(32'(u_way_i)));
    row_f  = touch(age_q[f_set_i], 32'(f_way_i));
    row_ub = age_q[u_set_i];
    if (f_eff && f_set_i == u_set_i) row_ub = touch(row_ub, 32'(f_way_i));
    row_u  = touch(row_ub, 32'(u_way_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int unsigned w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(in_br(w) ? w : w - BR_WAYS);
    end else begin
      if (f_eff && !(u_touch_i && f_set_i == u_set_i)) age_q[f_set_i] <= row_f;
      if (u_touch_i) age_q[u_set_i] <= row_u;
    end
  end

  always_comb begin
    logic             inv;
    logic [WAY_W-1:0] inv_w, old_w;
    logic [AGE_W-1:0] best;
    inv   = 1'b0;
    inv_w = '0;
    old_w = '0;
    best  = '0;
    for (int unsigned w = 0; w < WAYS; w++) begin
      if (in_br(w) == u_br_i && age_q[u_set_i][w] >= best) begin
        best  = age_q[u_set_i][w];
        old_w = WAY_W'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (in_br(32'(w)) == u_br_i && !u_vld_i[w]) begin
        inv   = 1'b1;
        inv_w = WAY_W'(w);
      end
    end
    victim_o = inv ? inv_w : old_w;
  end

  AST_VICTIM_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u_touch_i |-> (u_br_i == (32'(victim_o) < BR_WAYS))); // R5
endmodule

// File: rtl/wp_btb.sv
module wp_btb
  import wp_btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned SETS    = 64,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned BR_WAYS = 2,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_valid_i,
  input  logic [PC_W-1:0]     fetch_pc_i,
  output logic                hit_o,
  output logic                is_br_o,
  output logic [PC_W-1:0]     tgt_o,
  output logic                wp_valid_o,
  output logic [IC_WAY_W-1:0] wp_way_o,
  output logic [IC_WAYS-1:0]  way_en_o,
  input  logic                upd_valid_i,
  input  logic [PC_W-1:0]     upd_pc_i,
  input  logic                upd_is_br_i,
  input  logic [PC_W-1:0]     upd_tgt_i,
  input  logic [IC_WAY_W-1:0] upd_way_i,
  output logic                mispred_o
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = PC_W - SET_W - IDX_LSB;
  localparam logic [WAYS-1:0] BR_MASK = WAYS'((1 << BR_WAYS) - 1);

  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][PC_W-1:0]  tgt_q [SETS];
  logic [WAYS-1:0][IC_WAY_W-1:0] icw_q [SETS];
  logic mispred_q;

  logic [SET_W-1:0] f_set, u_set;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic [WAYS-1:0]  f_hitv, u_hitv, u_mask, u_same, u_oth;
  logic [WAY_W-1:0] f_idx, u_idx, u_sel, victim;
  logic             f_hit, u_match;

  function automatic logic [WAY_W-1:0] lowest(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  assign f_set = fetch_pc_i[IDX_LSB +: SET_W];
  assign f_tag = fetch_pc_i[PC_W-1 -: TAG_W];
  assign u_set = upd_pc_i[IDX_LSB +: SET_W];
  assign u_tag = upd_pc_i[PC_W-1 -: TAG_W];

  logic unused_pc_lsb;
  assign unused_pc_lsb = ^{fetch_pc_i[IDX_LSB-1:0], upd_pc_i[IDX_LSB-1:0]};

  wp_btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fetch_match (
    .vld_i(vld_q[f_set]), .tag_i(tag_q[f_set]), .q_i(f_tag), .hit_o(f_hitv)
  );
  wp_btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd_match (
    .vld_i(vld_q[u_set]), .tag_i(tag_q[u_set]), .q_i(u_tag), .hit_o(u_hitv)
  );

  // fetch side
  assign f_idx      = lowest(f_hitv);
  assign f_hit      = fetch_valid_i && (|f_hitv);
  assign hit_o      = f_hit;
  assign wp_valid_o = f_hit;
  assign is_br_o    = f_hit && BR_MASK[f_idx];
  assign tgt_o      = is_br_o ? tgt_q[f_set][f_idx] : '0;
  assign wp_way_o   = f_hit ? icw_q[f_set][f_idx] : '0;
  assign way_en_o   = f_hit ? icway_dec(wp_way_o) : '1;

  // update side
  assign u_mask  = upd_is_br_i ? BR_MASK : ~BR_MASK;
  assign u_same  = u_hitv & u_mask;
  assign u_oth   = u_hitv & ~u_mask;
  assign u_match = |u_same;
  assign u_idx   = lowest(u_same);
  assign u_sel   = u_match ? u_idx : victim;

  wp_btb_repl #(.SETS(SETS), .WAYS(WAYS), .BR_WAYS(BR_WAYS)) u_repl (
    .clk_i, .rst_ni,
    .f_touch_i(f_hit), .f_set_i(f_set), .f_way_i(f_idx),
    .u_touch_i(upd_valid_i), .u_set_i(u_set), .u_way_i(u_sel),
    .u_br_i(upd_is_br_i), .u_vld_i(vld_q[u_set]), .victim_o(victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      mispred_q <= 1'b0;
    end else begin
      mispred_q <= upd_valid_i && u_match && (icw_q[u_set][u_idx] != upd_way_i);
      if (upd_valid_i) begin
        for (int w = 0; w < WAYS; w++) if (u_oth[w]) vld_q[u_set][w] <= 1'b0;
        vld_q[u_set][u_sel] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (upd_valid_i) begin
      tag_q[u_set][u_sel] <= u_tag;
      tgt_q[u_set][u_sel] <= upd_tgt_i;
      icw_q[u_set][u_sel] <= upd_way_i;
    end
  end

  assign mispred_o = mispred_q;

  AST_HIT_ONEHOT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $onehot(way_en_o)); // R3
  AST_MISS_ALL_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (way_en_o == '1)); // R3
  AST_NONBR_ZERO_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !is_br_o) |-> (tgt_o == '0)); // R4
  AST_MISPRED_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_o |-> $past(upd_valid_i)); // R7
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !hit_o); // R10
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(f_hitv)); // R5
endmodule

// File: tb/wp_btb_test.sv
module wp_btb_test;
  localparam int PC_W = 16, SETS = 4, WAYS = 4, BR = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 0, uv = 0, ubr = 0;
  logic [PC_W-1:0] fpc = '0, upc = '0, utgt = '0;
  logic [1:0] uway = '0;
  logic hit, isbr, wpv, mis;
  logic [PC_W-1:0] tgt;
  logic [1:0] wway;
  logic [3:0] wen;

  int checks = 0, errors = 0;
  bit m_v [SETS][WAYS];
  int m_tag [SETS][WAYS], m_tgt [SETS][WAYS], m_way [SETS][WAYS], m_age [SETS][WAYS];
  bit exp_mis = 0;

  always #10 clk = ~clk;

  wp_btb #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .BR_WAYS(BR), .IDX_LSB(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_pc_i(fpc),
    .hit_o(hit), .is_br_o(isbr), .tgt_o(tgt), .wp_valid_o(wpv), .wp_way_o(wway),
    .way_en_o(wen), .upd_valid_i(uv), .upd_pc_i(upc), .upd_is_br_i(ubr),
    .upd_tgt_i(utgt), .upd_way_i(uway), .mispred_o(mis)
  );

  function automatic logic [PC_W-1:0] mk(int t, int s);
    return PC_W'((t << 4) | (s << 2));
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  function automatic int find(int s, int t, int lo, int hi);
    for (int w = lo; w < hi; w++) if (m_v[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic void mtouch(int s, int w);
    int a = m_age[s][w];
    for (int x = 0; x < WAYS; x++)
      if ((x < BR) == (w < BR) && m_age[s][x] < a) m_age[s][x]++;
    m_age[s][w] = 0;
  endfunction

  task automatic cyc(string r, bit f_v, logic [PC_W-1:0] f_pc, bit u_v,
                     logic [PC_W-1:0] u_pc, bit u_br, int u_tgt, int u_way);
    int fs, ft, fi, us, ut, lo, hi, sel, ow;
    bit ehit, ebr, feff;
    @(negedge clk);
    fv = f_v; fpc = f_pc; uv = u_v; upc = u_pc; ubr = u_br;
    utgt = PC_W'(u_tgt); uway = 2'(u_way);
    #5;
    fs = int'(f_pc[3:2]); ft = int'(f_pc[15:4]);
    fi = find(fs, ft, 0, WAYS);
    ehit = f_v && fi >= 0;
    ebr  = ehit && fi < BR;
    chk(r, "hit(R2)", int'(hit), int'(ehit));
    chk(r, "wp_valid(R2)", int'(wpv), int'(ehit));
    chk(r, "is_br(R4)", int'(isbr), int'(ebr));
    chk(r, "tgt(R4)", int'(tgt), ebr ? m_tgt[fs][fi] : 0);
    chk(r, "wp_way(R2)", int'(wway), ehit ? m_way[fs][fi] : 0);
    chk(r, "way_en(R3)", int'(wen), ehit ? (1 << m_way[fs][fi]) : 15);
    chk(r, "mispred(R7)", int'(mis), int'(exp_mis));
    // model next state from pre-edge state
    us = int'(u_pc[3:2]); ut = int'(u_pc[15:4]);
    lo = u_br ? 0 : BR; hi = u_br ? BR : WAYS;
    sel = find(us, ut, lo, hi);
    ow  = find(us, ut, u_br ? BR : 0, u_br ? WAYS : BR);
    exp_mis = u_v && sel >= 0 && m_way[us][sel] != u_way;
    if (u_v && sel < 0) begin
      for (int w = hi - 1; w >= lo; w--) if (!m_v[us][w] && sel < 0) sel = w;
      if (sel < 0) for (int w = lo; w < hi; w++) if (m_age[us][w] == hi - lo - 1) sel = w;
    end
    feff = ehit && !(u_v && fs == us && ((fi < BR) == u_br));
    @(posedge clk);
    if (feff) mtouch(fs, fi);
    if (u_v) begin
      mtouch(us, sel);
      if (ow >= 0) m_v[us][ow] = 0;
      m_v[us][sel] = 1; m_tag[us][sel] = ut;
      m_tgt[us][sel] = u_tgt & 16'hffff; m_way[us][sel] = u_way;
    end
  endtask

  task automatic fetch(string r, logic [PC_W-1:0] p);
    cyc(r, 1, p, 0, '0, 0, 0, 0);
  endtask
  task automatic upd(string r, logic [PC_W-1:0] p, bit b, int t, int w);
    cyc(r, 0, '0, 1, p, b, t, w);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_age[s][w] = (w < BR) ? w : w - BR;
      end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    fetch("R1", mk(1, 0));
    upd("R5", mk(1, 0), 1, 16'h1234, 2);
    fetch("R2", mk(1, 0));
    upd("R4", mk(2, 0), 0, 16'h5555, 1);
    fetch("R4", mk(2, 0));
    upd("R6", mk(2, 0), 0, 0, 3);
    fetch("R7", mk(2, 0));
    upd("R6", mk(2, 0), 0, 0, 3);
    fetch("R7", mk(2, 0));
    upd("R8", mk(3, 0), 0, 0, 0);
    upd("R8", mk(4, 0), 0, 0, 1);
    fetch("R9", mk(3, 0));
    upd("R8", mk(5, 0), 0, 0, 2);
    fetch("R8", mk(2, 0));
    fetch("R8", mk(3, 0));
    fetch("R8", mk(4, 0));
    cyc("R9", 1, mk(3, 0), 1, mk(6, 0), 0, 0, 3);
    fetch("R9", mk(3, 0));
    upd("R5", mk(1, 0), 0, 0, 0);
    fetch("R5", mk(1, 0));
    fetch("R10", mk(1, 1));
    cyc("R10", 0, mk(3, 0), 0, '0, 0, 0, 0);
    for (int i = 0; i < 4000; i++)
      cyc("RND", ($urandom % 4) != 0, mk($urandom % 6, $urandom % 4),
          $urandom % 2, mk($urandom % 6, $urandom % 4), $urandom % 2,
          $urandom % 65536, $urandom % 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule